// File: doc/BRIEF.md
# Capture / Reload / Baud-Rate Timer

This block is a 16-bit counter with three uses. It can time machine cycles or count falling edges on an external count pin. In capture mode, a falling edge on a second external control pin snapshots the running count into a holding register. In reload mode, the count restarts from the holding register when it wraps, and it can optionally count down, with the control pin's level choosing the direction. In baud mode, the counter runs at a faster rate and reloads on every wrap, and every sixteenth wrap produces a one-clock tick for a serial port.

The mode comes from control inputs. Either baud request selects baud mode, and baud mode outranks the capture select. Software loads the count, the holding register and the two flags through a single write port with a select field. The write port always wins over any hardware update in the same cycle. The interrupt request is the OR of the two flags.

Top module: `tcr_timer`

## Requirements
- R1: After a synchronous reset, the count, the holding register, both flags, the interrupt and the baud tick are all 0.
- R2: In timer mode (count_sel=0, not baud) with run_en=1, the count advances by one once every 12 clocks (one machine cycle).
- R3: With count_sel=1, cnt_pin is sampled once per machine cycle. A sample of 1 followed by a sample of 0 advances the count by one at the next machine-cycle boundary. Levels held for 24 clocks are each counted.
- R4: In capture mode (cap_sel=1), a step from FFFFh gives 0000h and sets ovf_flag. irq equals ovf_flag OR ext_flag.
- R5: In capture mode with ext_en=1, a falling edge on ctl_pin (sampled the same way as in R3) copies the count into the holding register and sets ext_flag. This also happens when run_en=0. If a capture and a wrap land on the same machine cycle, the value captured is FFFFh and both flags are set.
- R6: In reload mode with dir_en=0, a step from FFFFh loads the holding register into the count and sets ovf_flag.
- R7: In reload mode with dir_en=0 and ext_en=1, a ctl_pin falling edge loads the holding register into the count and sets ext_flag, even when stopped.
- R8: In reload mode with dir_en=1 and ctl_pin sampled low, the count decrements. When the count equals the holding register, the next step loads FFFFh, sets ovf_flag and toggles ext_flag.
- R9: In reload mode with dir_en=1 and ctl_pin sampled high, the count increments. A step from FFFFh loads the holding register, sets ovf_flag and toggles ext_flag.
- R10: In baud mode (rx_baud or tx_baud set), the count steps every 2 clocks. It reloads from the holding register after FFFFh and never sets ovf_flag. A ctl_pin falling edge with ext_en=1 sets ext_flag but changes neither register.
- R11: In baud mode, baud_tick pulses for one clock once per 16 wraps.
- R12: wr_sel encodes the write target: 0 is the count, 1 is the holding register, and 2 is the flags, with wr_data bit 0 going to ovf_flag and bit 1 to ext_flag. A write to the count takes effect in place of a same-cycle step.
- R13: With run_en=0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable |
| count_sel | input | 1 | 1: count cnt_pin edges; 0: count machine cycles |
| cap_sel | input | 1 | 1: capture mode; 0: reload mode |
| ext_en | input | 1 | Enables ctl_pin edge actions |
| dir_en | input | 1 | Lets ctl_pin level choose direction in reload mode |
| rx_baud | input | 1 | Baud mode request, receive side |
| tx_baud | input | 1 | Baud mode request, transmit side |
| cnt_pin | input | 1 | External count input |
| ctl_pin | input | 1 | External capture/reload/direction input |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 count, 1 holding, 2 flags |
| wr_data | input | 16 | Write data |
| cnt_val | output | 16 | Current count |
| rld_val | output | 16 | Holding (capture/reload) register |
| ovf_flag | output | 1 | Wrap flag |
| ext_flag | output | 1 | External-event / direction flag |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | One-clock tick every 16 baud wraps |

## Verification
A capture and a wrap can happen on the same machine-cycle boundary. In capture mode, the bench stops the counter, loads FFFDh, restarts it and aligns to the first step. It then drops ctl_pin so that the edge is acted on in exactly the cycle where the count wraps. The bench expects a captured value of FFFFh, a count of 0000h and both flags set. A software write to the count that coincides with a machine-cycle step is also set up, and the written value, not the incremented one, must appear.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  typedef enum logic [1:0] {
    MD_RELOAD  = 2'd0,
    MD_CAPTURE = 2'd1,
    MD_BAUD    = 2'd2
  } tcr_mode_e;

  localparam logic [1:0] SEL_CNT = 2'd0;
  localparam logic [1:0] SEL_RLD = 2'd1;
  localparam logic [1:0] SEL_FLG = 2'd2;
endpackage

// File: rtl/tcr_prescale.sv
module tcr_prescale #(
  parameter int LEN = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/tcr_pin_sampler.sv
module tcr_pin_sampler (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  input  logic pin,
  output logic lvl,
  output logic fall
);
  logic smp_q, smp_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q   <= 1'b0;
      smp_d_q <= 1'b0;
    end else if (sample) begin
      smp_q   <= pin;
      smp_d_q <= smp_q;
    end
  end

  assign lvl  = smp_q;
  assign fall = smp_d_q & ~smp_q;
endmodule

// File: rtl/tcr_core.sv
module tcr_core
  import tcr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int BAUD_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  tcr_mode_e        mode,
  input  logic             run_en,
  input  logic             count_sel,
  input  logic             ext_en,
  input  logic             dir_en,
  input  logic             mc_tick,
  input  logic             half_tick,
  input  logic             cnt_fall,
  input  logic             ctl_fall,
  input  logic             ctl_lvl,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_val,
  output logic [CNT_W-1:0] rld_val,
  output logic             ovf_flag,
  output logic             ext_flag,
  output logic             irq,
  output logic             baud_tick
);
  localparam logic [CNT_W-1:0] ONES = '1;
  localparam int DIV_W = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BAUD_DIV - 1);

  logic [CNT_W-1:0] cnt_q, rld_q, cnt_nx;
  logic             ovf_q, ext_q, btick_q;
  logic [DIV_W-1:0] div_q;

  logic wr_cnt, wr_rld, wr_flg;
  logic pin_ev, ctl_ev, step, wrap, tgl;
  logic cap_ev, ext_rl, ext_set, ext_tgl, ovf_set, baud_ovf;
  logic baud_m, cap_m, rel_m;

  assign baud_m = (mode == MD_BAUD);
  assign cap_m  = (mode == MD_CAPTURE);
  assign rel_m  = (mode == MD_RELOAD);

  assign wr_cnt = wr_en && (wr_sel == SEL_CNT);
  assign wr_rld = wr_en && (wr_sel == SEL_RLD);
  assign wr_flg = wr_en && (wr_sel == SEL_FLG);

  assign pin_ev = mc_tick & cnt_fall;
  assign ctl_ev = mc_tick & ctl_fall;
  assign step   = run_en & (count_sel ? pin_ev : (baud_m ? half_tick : mc_tick));

  always_comb begin
    cnt_nx = cnt_q + 1'b1;
    wrap   = 1'b0;
    tgl    = 1'b0;
    unique case (mode)
      MD_BAUD: begin
        if (cnt_q == ONES) begin
          cnt_nx = rld_q;
          wrap   = 1'b1;
        end
      end
      MD_CAPTURE: begin
        if (cnt_q == ONES) wrap = 1'b1;
      end
      default: begin
        if (dir_en && !ctl_lvl) begin
          if (cnt_q == rld_q) begin
            cnt_nx = ONES;
            wrap   = 1'b1;
          end else begin
            cnt_nx = cnt_q - 1'b1;
          end
        end else if (cnt_q == ONES) begin
          cnt_nx = rld_q;
          wrap   = 1'b1;
        end
        tgl = dir_en & wrap;
      end
    endcase
  end

  assign cap_ev   = cap_m & ext_en & ctl_ev;
  assign ext_rl   = rel_m & ~dir_en & ext_en & ctl_ev;
  assign ext_set  = ext_en & ctl_ev & ~(rel_m & dir_en);
  assign ext_tgl  = step & tgl & ~wr_cnt;
  assign ovf_set  = step & wrap & ~baud_m & ~wr_cnt & ~ext_rl;
  assign baud_ovf = step & wrap & baud_m & ~wr_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      rld_q   <= '0;
      ovf_q   <= 1'b0;
      ext_q   <= 1'b0;
      div_q   <= '0;
      btick_q <= 1'b0;
    end else begin
      btick_q <= 1'b0;
      if (wr_cnt)      cnt_q <= wr_data;
      else if (ext_rl) cnt_q <= rld_q;
      else if (step)   cnt_q <= cnt_nx;

      if (wr_rld)      rld_q <= wr_data;
      else if (cap_ev) rld_q <= cnt_q;

      if (wr_flg) begin
        ovf_q <= wr_data[0];
        ext_q <= wr_data[1];
      end else begin
        if (ovf_set) ovf_q <= 1'b1;
        if (ext_set)      ext_q <= 1'b1;
        else if (ext_tgl) ext_q <= ~ext_q;
      end

      if (baud_ovf) begin
        if (div_q == DIV_LAST) begin
          div_q   <= '0;
          btick_q <= 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign cnt_val   = cnt_q;
  assign rld_val   = rld_q;
  assign ovf_flag  = ovf_q;
  assign ext_flag  = ext_q;
  assign irq       = ovf_q | ext_q;
  assign baud_tick = btick_q;

  // R12
  wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> cnt_q == $past(wr_data));
  // R2
  cap_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_m && step && !wr_cnt && cnt_q != ONES) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R5
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_ev && !wr_rld) |=> rld_q == $past(cnt_q));
  // R10
  baud_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> (!$past(baud_m) || $past(wr_flg)));
  // R11
  baud_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    btick_q |=> !btick_q);
  // R13
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !wr_cnt && !ext_rl) |=> $stable(cnt_q));
endmodule

// File: rtl/tcr_timer.sv
module tcr_timer
  import tcr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int CYC_LEN  = 12,
  parameter int BAUD_PRE = 2,
  parameter int BAUD_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             count_sel,
  input  logic             cap_sel,
  input  logic             ext_en,
  input  logic             dir_en,
  input  logic             rx_baud,
  input  logic             tx_baud,
  input  logic             cnt_pin,
  input  logic             ctl_pin,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_val,
  output logic [CNT_W-1:0] rld_val,
  output logic             ovf_flag,
  output logic             ext_flag,
  output logic             irq,
  output logic             baud_tick
);
  tcr_mode_e mode;
  logic mc_tick, half_tick;
  logic cnt_lvl, cnt_fall, ctl_lvl, ctl_fall;

  always_comb begin
    if (rx_baud || tx_baud) mode = MD_BAUD;
    else if (cap_sel)       mode = MD_CAPTURE;
    else                    mode = MD_RELOAD;
  end

  tcr_prescale #(.LEN(CYC_LEN)) u_mc (
    .clk(clk), .rst(rst), .tick(mc_tick));

  tcr_prescale #(.LEN(BAUD_PRE)) u_half (
    .clk(clk), .rst(rst), .tick(half_tick));

  tcr_pin_sampler u_cnt_pin (
    .clk(clk), .rst(rst), .sample(mc_tick), .pin(cnt_pin),
    .lvl(cnt_lvl), .fall(cnt_fall));

  tcr_pin_sampler u_ctl_pin (
    .clk(clk), .rst(rst), .sample(mc_tick), .pin(ctl_pin),
    .lvl(ctl_lvl), .fall(ctl_fall));

  logic unused_lvl;
  assign unused_lvl = cnt_lvl;

  tcr_core #(.CNT_W(CNT_W), .BAUD_DIV(BAUD_DIV)) u_core (
    .clk(clk), .rst(rst), .mode(mode),
    .run_en(run_en), .count_sel(count_sel), .ext_en(ext_en), .dir_en(dir_en),
    .mc_tick(mc_tick), .half_tick(half_tick),
    .cnt_fall(cnt_fall), .ctl_fall(ctl_fall), .ctl_lvl(ctl_lvl),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_val(cnt_val), .rld_val(rld_val),
    .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq), .baud_tick(baud_tick));
endmodule

// File: tb/tcr_timer_bench.sv
`timescale 1ns/1ps
module tcr_timer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 0, count_sel = 0, cap_sel = 0, ext_en = 0, dir_en = 0;
  logic rx_baud = 0, tx_baud = 0, cnt_pin = 0, ctl_pin = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] cnt_val, rld_val;
  logic ovf_flag, ext_flag, irq, baud_tick;

  always #10 clk = ~clk;

  tcr_timer u_tcr_timer (
    .clk(clk), .rst(rst), .run_en(run_en), .count_sel(count_sel),
    .cap_sel(cap_sel), .ext_en(ext_en), .dir_en(dir_en),
    .rx_baud(rx_baud), .tx_baud(tx_baud), .cnt_pin(cnt_pin), .ctl_pin(ctl_pin),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_val(cnt_val), .rld_val(rld_val), .ovf_flag(ovf_flag),
    .ext_flag(ext_flag), .irq(irq), .baud_tick(baud_tick));

  typedef struct {
    string       req;
    int          sig;
    logic [15:0] exp;
    logic [15:0] act;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_run = 0, n_fail = 0;
  bit    done = 0;

  // scoreboard monitor
  always @(chk_ev) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] a;
      it = q.pop_front();
      case (it.sig)
        0: a = cnt_val;
        1: a = rld_val;
        2: a = {15'd0, ovf_flag};
        3: a = {15'd0, ext_flag};
        4: a = {15'd0, irq};
        5: a = {15'd0, baud_tick};
        default: a = it.act;
      endcase
      n_run++;
      if (a !== it.exp) begin
        n_fail++;
        $display("FAIL %s sig%0d actual=%h expected=%h", it.req, it.sig, a, it.exp);
      end
    end
  end

  task automatic chk(string req, int sig, logic [15:0] exp, logic [15:0] act = 0);
    item_t it;
    it.req = req; it.sig = sig; it.exp = exp; it.act = act;
    q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic at_neg();
    @(negedge clk); #1;
  endtask

  task automatic clocks(int n);
    repeat (n) @(posedge clk);
    at_neg();
  endtask

  task automatic wr(logic [1:0] s, logic [15:0] d);
    @(posedge clk); #2;
    wr_en = 1; wr_sel = s; wr_data = d;
    @(posedge clk); #2;
    wr_en = 0;
    at_neg();
  endtask

  task automatic wait_change();
    logic [15:0] v;
    v = cnt_val;
    for (int i = 0; i < 200; i++) begin
      at_neg();
      if (cnt_val !== v) break;
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int per;
    repeat (3) @(posedge clk);
    #2 rst = 0;
    at_neg();
    // R1 reset state
    chk("R1", 0, 16'h0000); chk("R1", 1, 16'h0000); chk("R1", 2, 0);
    chk("R1", 3, 0); chk("R1", 4, 0); chk("R1", 5, 0);

    // R2 timer rate
    run_en = 1;
    wait_change();
    v = cnt_val;
    clocks(12 * 5);
    chk("R2", 0, v + 16'd5);

    // R12 write beats same-cycle step
    wait_change();
    repeat (11) @(posedge clk);
    #2 wr_en = 1; wr_sel = 2'd0; wr_data = 16'hABCD;
    @(posedge clk); #2 wr_en = 0;
    at_neg();
    chk("R12", 0, 16'hABCD);
    clocks(12);
    chk("R2", 0, 16'hABCE);

    // R13 stopped holds
    run_en = 0;
    clocks(2);
    v = cnt_val;
    clocks(48);
    chk("R13", 0, v);

    // R3 counter mode
    count_sel = 1; cnt_pin = 1;
    wr(2'd0, 16'h0000);
    clocks(24);
    run_en = 1;
    for (int k = 0; k < 4; k++) begin
      cnt_pin = 0; clocks(24);
      cnt_pin = 1; clocks(24);
    end
    clocks(36);
    chk("R3", 0, 16'h0004);
    run_en = 0; count_sel = 0;

    // R5 capture while stopped
    cap_sel = 1; ext_en = 1; ctl_pin = 1;
    clocks(24);
    wr(2'd0, 16'h3C3C);
    ctl_pin = 0; clocks(36);
    chk("R5", 1, 16'h3C3C); chk("R5", 3, 1); chk("R4", 4, 1);
    chk("R5", 0, 16'h3C3C);
    ctl_pin = 1; clocks(24);
    wr(2'd2, 16'h0000);
    chk("R12", 4, 0);

    // R5 + R4 capture and wrap in the same machine cycle
    wr(2'd0, 16'hFFFD);
    run_en = 1;
    wait_change();
    chk("R4", 0, 16'hFFFE);
    ctl_pin = 0;
    clocks(24);
    chk("R5", 1, 16'hFFFF); chk("R4", 0, 16'h0000);
    chk("R4", 2, 1); chk("R5", 3, 1);
    run_en = 0; ctl_pin = 1; ext_en = 0; cap_sel = 0;
    clocks(24);
    wr(2'd2, 16'h0000);

    // R6 up reload
    wr(2'd1, 16'h1234);
    wr(2'd0, 16'hFFFF);
    run_en = 1;
    wait_change();
    chk("R6", 0, 16'h1234); chk("R6", 2, 1);
    run_en = 0;
    clocks(2);
    wr(2'd2, 16'h0000);

    // R7 reload by edge
    ext_en = 1;
    wr(2'd0, 16'h0500);
    wr(2'd1, 16'h0077);
    ctl_pin = 0; clocks(36);
    chk("R7", 0, 16'h0077); chk("R7", 3, 1); chk("R7", 2, 0);
    ctl_pin = 1; clocks(24);
    ext_en = 0;
    wr(2'd2, 16'h0000);

    // R8 down count
    dir_en = 1; ctl_pin = 0; clocks(24);
    wr(2'd1, 16'h0010);
    wr(2'd0, 16'h0012);
    run_en = 1;
    wait_change();
    chk("R8", 0, 16'h0011);
    clocks(12);
    chk("R8", 0, 16'h0010);
    clocks(12);
    chk("R8", 0, 16'hFFFF); chk("R8", 2, 1); chk("R8", 3, 1);
    run_en = 0;

    // R9 up with direction enabled
    ctl_pin = 1; clocks(24);
    wr(2'd2, 16'h0002);
    wr(2'd0, 16'hFFFF);
    run_en = 1;
    wait_change();
    chk("R9", 0, 16'h0010); chk("R9", 2, 1); chk("R9", 3, 0);
    run_en = 0; dir_en = 0;
    clocks(2);
    wr(2'd2, 16'h0000);

    // R10 / R11 baud mode
    rx_baud = 1;
    wr(2'd1, 16'hFFFC);
    wr(2'd0, 16'hFFFC);
    run_en = 1;
    wait_change();
    v = cnt_val;
    clocks(2);
    chk("R10", 0, (v == 16'hFFFF) ? 16'hFFFC : v + 16'd1);
    for (int i = 0; i < 400; i++) begin
      at_neg();
      if (baud_tick) break;
    end
    per = 0;
    for (int i = 1; i < 400; i++) begin
      at_neg();
      if (baud_tick) begin per = i; break; end
    end
    chk("R11", 7, 16'd128, 16'(per));
    chk("R10", 2, 0);
    ext_en = 1; ctl_pin = 0; clocks(36);
    chk("R10", 3, 1); chk("R10", 1, 16'hFFFC); chk("R10", 2, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule